// File: doc/BRIEF.md
# Aligned interrupt-entry block allocator

This block keeps the occupancy bits of an interrupt remapping table in on-chip flops and hands out naturally aligned, power-of-two sized groups of entries. A caller asks for some number of entries. The block rounds that number up to a power of two and scans the table from entry 0, one aligned candidate group per clock. It marks the first empty group as used and returns its base index together with the size exponent (the mask).

A caller hands a group back by giving its base index and mask. The block clears those entries at once and raises a one-cycle invalidation request carrying the same index and mask, so that a downstream entry cache can drop any stale copy. Requests use a valid/ready handshake. Only one operation runs at a time. Each operation ends with a single-cycle response that carries a status flag.

Top module: `irq_blk_alloc`

## Requirements
- R1: An allocation with `req_count` = 0 returns `rsp_err` = 1 one cycle after acceptance and leaves `present_o` unchanged.
- R2: The response mask is the smallest m with 2^m >= `req_count`, so a count of 1 gives mask 0, a count of 3 gives mask 2 and a count of 9 gives mask 4.
- R3: When the rounded mask is above `max_mask`, or above log2 of the table size, the allocation fails one cycle after acceptance. No search is done and `present_o` is unchanged.
- R4: The search starts at index 0 and checks one candidate group per clock. A response that follows k checked candidates arrives k+1 cycles after acceptance.
- R5: Candidates are spaced by the rounded group size. The first group with no occupied entry is chosen, so a returned base index is always a multiple of 2^mask.
- R6: When the step past the last candidate wraps back to index 0, the allocation fails with `rsp_err` = 1 after N/2^mask checks, and `present_o` is unchanged.
- R7: A successful allocation sets exactly the 2^mask occupancy bits starting at the returned index, and those bits are visible on `present_o`.
- R8: A release (`req_op` = 1) clears the 2^mask bits starting at `req_index`. It answers one cycle after acceptance with `rsp_err` = 0 and echoes the index and mask.
- R9: A release raises `inv_valid` for exactly one cycle, in the same cycle as its response, with `inv_index` and `inv_mask` equal to the released group.
- R10: `req_ready` is low while a search is in progress and high otherwise. `inv_valid` never rises during a search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears every occupancy bit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 1 | 0 = allocate, 1 = release |
| req_count | input | 7 | Entries wanted (allocate) |
| req_index | input | 6 | Base index of group to release |
| req_mask | input | 3 | Size exponent of group to release |
| max_mask | input | 3 | Largest mask an allocation may use |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | 0 = success, 1 = error |
| rsp_index | output | 6 | Base index of the group (0 on error) |
| rsp_mask | output | 3 | Size exponent of the group |
| inv_valid | output | 1 | One-cycle invalidation request |
| inv_index | output | 6 | Index to invalidate |
| inv_mask | output | 3 | Mask of the invalidation |
| present_o | output | 64 | Occupancy bit of each table entry |

## Verification
The assertions check on every cycle that a successful allocation comes back aligned, that it stays within the mask cap and that its bits read as set. They also check that a release leaves its span clear and raises its invalidation together with a matching response, and that ready drops only after an allocation has been accepted. Only the bench's scenarios can show that the first free group is the one chosen, that rounding produces the right exponent, and that the response latency follows the number of candidates checked. The same holds for failure on a full table and for reuse of a released group.

// File: rtl/irq_blk_alloc.sv
module irq_blk_alloc #(
  parameter int TABLE_ENTRIES = 64
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      req_valid,
  output logic                                      req_ready,
  input  logic                                      req_op,
  input  logic [$clog2(TABLE_ENTRIES):0]            req_count,
  input  logic [$clog2(TABLE_ENTRIES)-1:0]          req_index,
  input  logic [$clog2($clog2(TABLE_ENTRIES)+2)-1:0] req_mask,
  input  logic [$clog2($clog2(TABLE_ENTRIES)+2)-1:0] max_mask,
  output logic                                      rsp_valid,
  output logic                                      rsp_err,
  output logic [$clog2(TABLE_ENTRIES)-1:0]          rsp_index,
  output logic [$clog2($clog2(TABLE_ENTRIES)+2)-1:0] rsp_mask,
  output logic                                      inv_valid,
  output logic [$clog2(TABLE_ENTRIES)-1:0]          inv_index,
  output logic [$clog2($clog2(TABLE_ENTRIES)+2)-1:0] inv_mask,
  output logic [TABLE_ENTRIES-1:0]                  present_o
);
  localparam int IDXW  = $clog2(TABLE_ENTRIES);
  localparam int CNTW  = IDXW + 1;
  localparam int MASKW = $clog2(IDXW + 2);
  localparam logic [MASKW-1:0] TOP_MASK = MASKW'(IDXW);
  localparam logic [IDXW:0]    ONE_EXT  = 1;

  typedef enum logic {ST_IDLE, ST_SEARCH} st_t;

  st_t                     st;
  logic [TABLE_ENTRIES-1:0] present;
  logic [IDXW-1:0]          cand;
  logic [MASKW-1:0]         blk_mask;

  function automatic logic [MASKW-1:0] ceil_log2(input logic [CNTW-1:0] c);
    logic [MASKW-1:0] m;
    m = '0;
    for (int i = 0; i < CNTW; i++)
      if ((CNTW'(1) << i) < c) m = MASKW'(i + 1);
    return m;
  endfunction

  function automatic logic [TABLE_ENTRIES-1:0] span(input logic [IDXW-1:0] base,
                                                   input logic [MASKW-1:0] m);
    logic [TABLE_ENTRIES-1:0] v;
    int off;
    for (int e = 0; e < TABLE_ENTRIES; e++) begin
      off  = e - int'(base);
      v[e] = (off >= 0) && (off < (1 << m));
    end
    return v;
  endfunction

  logic                     accept;
  logic [MASKW-1:0]         rnd_mask;
  logic                     alloc_bad;
  logic [TABLE_ENTRIES-1:0] cand_span;
  logic                     cand_free;
  logic [IDXW:0]            nxt;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rnd_mask  = ceil_log2(req_count);
  assign alloc_bad = (req_count == '0) || (rnd_mask > max_mask) || (rnd_mask > TOP_MASK);
  assign cand_span = span(cand, blk_mask);
  assign cand_free = ~|(present & cand_span);
  assign nxt       = {1'b0, cand} + (ONE_EXT << blk_mask);
  assign present_o = present;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      present   <= '0;
      cand      <= '0;
      blk_mask  <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_index <= '0;
      rsp_mask  <= '0;
      inv_valid <= 1'b0;
      inv_index <= '0;
      inv_mask  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      inv_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            if (req_op) begin
              present   <= present & ~span(req_index, req_mask);
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b0;
              rsp_index <= req_index;
              rsp_mask  <= req_mask;
              inv_valid <= 1'b1;
              inv_index <= req_index;
              inv_mask  <= req_mask;
            end else if (alloc_bad) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_index <= '0;
              rsp_mask  <= rnd_mask;
            end else begin
              st       <= ST_SEARCH;
              cand     <= '0;
              blk_mask <= rnd_mask;
            end
          end
        end
        ST_SEARCH: begin
          if (cand_free) begin
            present   <= present | cand_span;
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_index <= cand;
            rsp_mask  <= blk_mask;
            st        <= ST_IDLE;
          end else if (nxt[IDXW]) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_index <= '0;
            rsp_mask  <= blk_mask;
            st        <= ST_IDLE;
          end else begin
            cand <= nxt[IDXW-1:0];
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_blk_alloc_chk.sv
module irq_blk_alloc_chk #(
  parameter int TABLE_ENTRIES = 64
) (
  input logic                                       clk,
  input logic                                       rst_n,
  input logic                                       req_valid,
  input logic                                       req_ready,
  input logic                                       req_op,
  input logic [$clog2($clog2(TABLE_ENTRIES)+2)-1:0] max_mask,
  input logic                                       rsp_valid,
  input logic                                       rsp_err,
  input logic [$clog2(TABLE_ENTRIES)-1:0]           rsp_index,
  input logic [$clog2($clog2(TABLE_ENTRIES)+2)-1:0] rsp_mask,
  input logic                                       inv_valid,
  input logic [$clog2(TABLE_ENTRIES)-1:0]           inv_index,
  input logic [$clog2($clog2(TABLE_ENTRIES)+2)-1:0] inv_mask,
  input logic [TABLE_ENTRIES-1:0]                   present_o
);
  localparam int IDXW = $clog2(TABLE_ENTRIES);

  logic [TABLE_ENTRIES-1:0] rsp_span;
  logic [TABLE_ENTRIES-1:0] inv_span;
  logic [IDXW-1:0]          low_bits;
  logic                     alloc_ok;

  always_comb begin
    for (int e = 0; e < TABLE_ENTRIES; e++) begin
      rsp_span[e] = ((e - int'(rsp_index)) >= 0) && ((e - int'(rsp_index)) < (1 << rsp_mask));
      inv_span[e] = ((e - int'(inv_index)) >= 0) && ((e - int'(inv_index)) < (1 << inv_mask));
    end
    low_bits = IDXW'((1 << rsp_mask) - 1);
  end

  assign alloc_ok = rsp_valid && !rsp_err && !inv_valid;

  AST_INV_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (rsp_valid && !rsp_err && inv_index == rsp_index && inv_mask == rsp_mask)); // R9
  AST_ALLOC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> ((rsp_index & low_bits) == '0)); // R5
  AST_ALLOC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> ((present_o & rsp_span) == rsp_span)); // R7
  AST_FREE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> ((present_o & inv_span) == '0)); // R8
  AST_MASK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> (rsp_mask <= max_mask)); // R3
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> ($past(req_valid) && !$past(req_op))); // R10
  AST_NO_INV_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !inv_valid); // R10
endmodule

bind irq_blk_alloc irq_blk_alloc_chk #(.TABLE_ENTRIES(TABLE_ENTRIES)) u_chk (.*);

// File: tb/irq_blk_alloc_bench.sv
`timescale 1ns/1ps
module irq_blk_alloc_bench;
  localparam int N     = 64;
  localparam int IDXW  = 6;
  localparam int CNTW  = 7;
  localparam int MASKW = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_op = 1'b0;
  logic [CNTW-1:0]  req_count = '0;
  logic [IDXW-1:0]  req_index = '0;
  logic [MASKW-1:0] req_mask = '0;
  logic [MASKW-1:0] max_mask = 3'd7;
  logic             rsp_valid, rsp_err, inv_valid;
  logic [IDXW-1:0]  rsp_index, inv_index;
  logic [MASKW-1:0] rsp_mask, inv_mask;
  logic [N-1:0]     present_o;

  logic [N-1:0] model = '0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_blk_alloc #(.TABLE_ENTRIES(N)) u_irq_blk_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_count(req_count), .req_index(req_index), .req_mask(req_mask),
    .max_mask(max_mask), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_index(rsp_index),
    .rsp_mask(rsp_mask), .inv_valid(inv_valid), .inv_index(inv_index), .inv_mask(inv_mask),
    .present_o(present_o));

  task automatic chk(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic accept_req(input logic op, input int count, input int idx, input int m, output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_op = op;
    req_count = CNTW'(count); req_index = IDXW'(idx); req_mask = MASKW'(m);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!rsp_valid && cyc < 200) begin
      chk("R10", "ready low during search", {63'd0, req_ready}, 64'd0);
      chk("R4", "occupancy stable during search", present_o, model);
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic do_alloc(input string req, input int count);
    int m, size, idx, probes, cyc;
    bit found, bad;
    m = 0; size = 1;
    while (size < count) begin size *= 2; m++; end
    bad = (count == 0) || (m > int'(max_mask)) || (size > N);
    probes = 0; found = 0; idx = 0;
    if (!bad) begin
      while (!found && idx < N) begin
        probes++;
        if ((model & (((64'd1 << size) - 64'd1) << idx)) == '0 || (size == N && model == '0))
          found = 1;
        else
          idx += size;
      end
    end
    accept_req(1'b0, count, 0, 0, cyc);
    chk(req, "response valid", {63'd0, rsp_valid}, 64'd1);
    chk(req, "latency", 64'(cyc), 64'(1 + probes));
    chk(req, "error flag", {63'd0, rsp_err}, {63'd0, !found});
    chk(req, "mask", 64'(rsp_mask), 64'(m));
    if (found) begin
      chk(req, "index", 64'(rsp_index), 64'(idx));
      if (size == N) model = '1;
      else model = model | (((64'd1 << size) - 64'd1) << idx);
    end
    chk(req, "no invalidation", {63'd0, inv_valid}, 64'd0);
    @(negedge clk);
    chk(req, "occupancy", present_o, model);
    chk("R10", "ready after op", {63'd0, req_ready}, 64'd1);
  endtask

  task automatic do_free(input int idx, input int m);
    int cyc;
    accept_req(1'b1, 0, idx, m, cyc);
    chk("R8", "free latency", 64'(cyc), 64'd1);
    chk("R8", "free status", {62'd0, rsp_valid, rsp_err}, 64'd2);
    chk("R8", "free echo index", 64'(rsp_index), 64'(idx));
    chk("R9", "inv valid", {63'd0, inv_valid}, 64'd1);
    chk("R9", "inv index", 64'(inv_index), 64'(idx));
    chk("R9", "inv mask", 64'(inv_mask), 64'(m));
    model = model & ~(((64'd1 << (1 << m)) - 64'd1) << idx);
    chk("R8", "occupancy after free", present_o, model);
    @(negedge clk);
    chk("R9", "inv single cycle", {63'd0, inv_valid}, 64'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "reset ready", {63'd0, req_ready}, 64'd1);
    chk("R7", "reset occupancy", present_o, '0);
    chk("R9", "reset outputs", {62'd0, rsp_valid, inv_valid}, 64'd0);

    do_alloc("R1", 0);
    do_alloc("R2", 1);
    do_alloc("R2", 3);
    do_alloc("R5", 2);
    max_mask = 3'd2;
    do_alloc("R3", 5);
    max_mask = 3'd7;
    do_alloc("R3", 100);
    do_alloc("R6", 64);
    do_alloc("R4", 16);
    do_alloc("R4", 16);
    do_alloc("R4", 16);
    do_alloc("R6", 16);
    do_free(4, 2);
    do_alloc("R5", 4);
    do_free(16, 4);
    do_alloc("R2", 9);
    do_free(0, 1);
    do_alloc("R7", 1);
    do_alloc("R7", 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule